// File: doc/BRIEF.md
# Shared Signed Arithmetic Unit (abs, min, max, add, subtract)

This block computes one of five arithmetic results on two signed two's-complement operands: the absolute value of the first operand, their difference, their sum, their minimum or their maximum. A single adder/subtractor serves every operation. A small steering stage feeds it the right operands and carry-in. The sign of its difference, corrected for overflow, decides the comparisons. A datapath can drop it in as either an abs/max group or an abs/min/add/subtract group. The same hardware covers both roles, and the caller simply never issues the codes it does not need.

The arithmetic core is purely combinational. It is wrapped in one output register stage with a valid/ready handshake on both sides. A request moves in when `in_valid` and `in_ready` are both high. Its result is presented on the next cycle with `out_valid` high, and it stays there until the consumer takes it with `out_ready`. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. This gives full throughput, one result per cycle, with no bubble when the consumer is always ready. When the consumer stalls, back-pressure reaches the producer in the same cycle.

Operation codes on `in_op`: 000 abs(a), 001 a-b, 010 a+b, 011 min(a,b), 100 max(a,b). Codes 101 to 111 are unused.

Top module: `amm_unit`

## Requirements
- R1: With op code 000 the result is a when a is zero or positive and 0-a when a is negative; the most negative value yields itself.
- R2: With op code 001 the result is a-b reduced modulo 2^N (wrapping, no saturation).
- R3: With op code 010 the result is a+b reduced modulo 2^N (wrapping, no saturation).
- R4: With op code 011 the result is the smaller of a and b compared as signed numbers, correct even when a-b overflows.
- R5: With op code 100 the result is the larger of a and b compared as signed numbers, correct even when a-b overflows.
- R6: Op codes 101, 110 and 111 produce an all-zero result.
- R7: While `rst_n` is low and on the first cycle after it rises, `out_valid` is low and `in_ready` is high.
- R8: `in_ready` equals NOT `out_valid` OR `out_ready`. While `out_valid` is high and `out_ready` is low, `out_res` and `out_valid` hold their values and no new request is taken.
- R9: A request accepted at a clock edge appears on `out_res` with `out_valid` high directly after that edge. When `out_ready` drains the stage and there is no new request, `out_valid` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_a | input | N | First signed operand |
| in_b | input | N | Second signed operand |
| in_op | input | 3 | Operation code |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_res | output | N | Result |

## Verification
The bench builds the unit with N = 4. At that width, every pair of operands under every one of the eight operation codes can be pushed through the handshake in about two thousand cycles. This brings every overflow corner of the comparison within reach, along with the wrap of the most negative value under abs and the wrapping sums and differences. Separate sequences stall the consumer to check that the result is held and that `in_ready` drops, and then drain the stage to an empty state.

// File: rtl/amm_pkg.sv
package amm_pkg;
  typedef enum logic [2:0] {
    OP_ABS = 3'b000,
    OP_SUB = 3'b001,
    OP_ADD = 3'b010,
    OP_MIN = 3'b011,
    OP_MAX = 3'b100
  } amm_op_e;
endpackage

// File: rtl/amm_addsub.sv
module amm_addsub #(
  parameter int N = 16
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  input  logic         sub,
  output logic [N-1:0] sum,
  output logic         ovf
);
  localparam int MSB = N - 1;
  logic [N-1:0] y_eff;
  logic [N:0]   full;

  always_comb begin
    y_eff = y ^ {N{sub}};
    full  = {1'b0, x} + {1'b0, y_eff} + {{N{1'b0}}, sub};
    sum   = full[N-1:0];
    ovf   = (x[MSB] == y_eff[MSB]) && (sum[MSB] != x[MSB]);
  end
endmodule

// File: rtl/amm_core.sv
module amm_core
  import amm_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic [2:0]   op,
  output logic [N-1:0] res
);
  localparam int MSB = N - 1;
  localparam logic [N-1:0] MOST_NEG = {1'b1, {(N-1){1'b0}}};

  logic [N-1:0] x, y, sum;
  logic         sub, ovf, a_lt_b;

  // Operand steering onto the single shared adder/subtractor
  always_comb begin
    x   = a;
    y   = b;
    sub = 1'b1;
    case (op)
      OP_ABS: begin x = '0; y = a; sub = 1'b1; end
      OP_ADD: sub = 1'b0;
      default: ;
    endcase
  end

  amm_addsub #(.N(N)) u_addsub (
    .x(x), .y(y), .sub(sub), .sum(sum), .ovf(ovf)
  );

  // Signed a<b from the difference sign, corrected by overflow
  assign a_lt_b = sum[MSB] ^ ovf;

  always_comb begin
    case (op)
      OP_ABS:  res = a[MSB] ? sum : a;
      OP_SUB:  res = sum;
      OP_ADD:  res = sum;
      OP_MIN:  res = a_lt_b ? a : b;
      OP_MAX:  res = a_lt_b ? b : a;
      default: res = '0;
    endcase
  end

  always_comb begin
    if (op == OP_MIN)
      p_min_bound_r4: assert ($signed(res) <= $signed(a) && $signed(res) <= $signed(b));
    if (op == OP_MAX)
      p_max_bound_r5: assert ($signed(res) >= $signed(a) && $signed(res) >= $signed(b));
    if (op == OP_ABS && a != MOST_NEG)
      p_abs_sign_r1: assert (res[MSB] == 1'b0);
    if (op > OP_MAX)
      p_unused_zero_r6: assert (res == '0);
  end
endmodule

// File: rtl/amm_unit.sv
module amm_unit #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [N-1:0] in_a,
  input  logic [N-1:0] in_b,
  input  logic [2:0]   in_op,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [N-1:0] out_res
);
  logic [N-1:0] core_res;
  logic         take;

  amm_core #(.N(N)) u_core (
    .a(in_a), .b(in_b), .op(in_op), .res(core_res)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_res   <= core_res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res)));
  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);
  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !in_valid) |=> !out_valid);
  p_reset_r7: assert property (@(posedge clk)
    !rst_n |=> !out_valid);
endmodule

// File: tb/test_amm_unit.sv
`timescale 1ns/1ps
module test_amm_unit;
  localparam int W = 4;
  localparam int M = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic [2:0]   in_op = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_res;

  int total = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  amm_unit #(.N(W)) i_amm_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_op(in_op), .out_valid(out_valid),
    .out_ready(out_ready), .out_res(out_res)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int sx(input int v);
    return (v >= M/2) ? v - M : v;
  endfunction

  function automatic int model(input int op, input int a, input int b);
    int sa, sb, r;
    sa = sx(a);
    sb = sx(b);
    case (op)
      0: r = (sa < 0) ? -sa : sa;
      1: r = sa - sb;
      2: r = sa + sb;
      3: r = (sa < sb) ? sa : sb;
      4: r = (sa > sb) ? sa : sb;
      default: r = 0;
    endcase
    return ((r % M) + M) % M;
  endfunction

  function automatic string req_of(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    #(5.0 * 100000);
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 out_valid in reset", int'(out_valid), 0);
    chk("R7 in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 out_valid after reset", int'(out_valid), 0);

    // Exhaustive sweep at full throughput (R1..R6, R9)
    for (int op = 0; op < 8; op++) begin
      for (int a = 0; a < M; a++) begin
        for (int b = 0; b < M; b++) begin
          in_valid = 1'b1;
          in_op = op[2:0];
          in_a = a[W-1:0];
          in_b = b[W-1:0];
          @(posedge clk);
          @(negedge clk);
          chk(req_of(op), int'(out_res), model(op, a, b));
          if (!out_valid) chk("R9 out_valid after accept", 0, 1);
        end
      end
    end

    // Back-pressure (R8): result 7 - 2 = 5 is latched, then stall
    in_op = 3'b001; in_a = 4'd7; in_b = 4'd2; in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R9 latched diff", int'(out_res), 5);
    out_ready = 1'b0;
    in_op = 3'b010; in_a = 4'd1; in_b = 4'd1;
    #0.1;
    chk("R8 in_ready low on stall", int'(in_ready), 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 result held", int'(out_res), 5);
    chk("R8 valid held", int'(out_valid), 1);

    // Drain (R9): no new request, consumer ready
    in_valid = 1'b0;
    out_ready = 1'b1;
    #0.1;
    chk("R8 in_ready with out_ready", int'(in_ready), 1);
    @(posedge clk);
    @(negedge clk);
    chk("R9 drained", int'(out_valid), 0);
    chk("R8 in_ready when empty", int'(in_ready), 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule